// File: doc/BRIEF.md
# Track-and-Hold Acquisition Sequencer

This block sequences acquisitions into a bank of 32 channel code registers and one offset-channel register, each 14 bits wide. An address strobe picks a target: one channel by its 5-bit address, the offset register, or all 32 channels at once for a calibration pass. The sequencer then runs a 14-step successive-approximation search. It presents a trial code to an external DAC/comparator pair and reads back one comparator bit per step. When the search ends, it writes the final code into the target register or registers.

While a target is pending or being acquired, its output buffer is switched to the raw input, so the held output never shows a partial code. The busy output is low from the start of the search until the code has been stored. A track input that is low when the strobe arrives defers the search until track rises. A strobe that arrives while the sequencer is not idle is dropped.

Top module: `acq_sequencer`

## Requirements
- R1: On reset, all 32 channel registers and the offset register read 0, busy_n is 1, every buffer-source select is 0 and trial_code is 0.
- R2: When a strobe is sampled with track high, busy_n reads 0 from the first edge after that strobe for exactly 15 cycles (14 compare steps plus one store cycle), and then returns to 1.
- R3: The search tests bits from bit 13 down to bit 0. Each step presents trial_code = kept bits OR the bit under test, and keeps that bit when cmp_ge is 1. Outside a compare step, trial_code is 0.
- R4: The stored code is the final search result and appears in the target register in the same cycle that busy_n returns to 1. All other registers keep their values, and no register changes at any other time.
- R5: From the edge that takes the strobe until busy_n returns to 1, the buffer-source bit of the target is 1 and all other bits are 0.
- R6: When the strobe is sampled with track low, the target's buffer-source bit goes to 1 while busy_n stays 1. The search starts at the first edge that samples track high after a sample of track low, and busy_n falls after that edge.
- R7: When ofs_sel is 1 (and cal is 0), the offset register and ofs_src_in are targeted, and the address is ignored.
- R8: When cal is 1, all 32 channel registers take the same acquired code and all 32 buffer bits are 1. cal takes precedence over ofs_sel, and the offset register is left untouched.
- R9: A strobe sampled while the sequencer is waiting, searching or storing is dropped. It does not change the target and does not start another acquisition.
- R10: busy_n is never low for more than CODE_W+1 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | Request to acquire the given target |
| addr | input | 5 | Channel address |
| ofs_sel | input | 1 | Target the offset register instead of a channel |
| cal | input | 1 | Target all 32 channels at once |
| track | input | 1 | Low defers acquisition until its rising edge |
| cmp_ge | input | 1 | Comparator: input is at or above trial_code |
| trial_code | output | 14 | Trial level for the comparator DAC |
| busy_n | output | 1 | Low while searching or storing |
| ch_code | output | 448 | Channel registers, channel i at bits [14*i+13:14*i] |
| ofs_code | output | 14 | Offset-channel register |
| buf_src_in | output | 32 | Per-channel buffer source, 1 means raw input |
| ofs_src_in | output | 1 | Offset buffer source, 1 means raw input |

## Verification
If a strobe is taken at edge k with track high, busy_n reads low after edges k through k+14 and high after edge k+15. The new code is visible in the same sample in which busy_n returns high. trial_code for step j is due after edge k+j, for j from 0 to 13. With track low, the same counts apply, measured from the edge that first samples track high. The bench drives and samples only on falling clock edges. It counts busy-low samples instead of waiting for an event, so a result that is one cycle early or late shows up as a wrong count. Its comparator model is a combinational compare of a chosen input code against trial_code, so each stored code is known in advance.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int unsigned ACQ_NCH_DEF    = 32;
  localparam int unsigned ACQ_CODE_W_DEF = 14;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SEARCH = 2'd2,
    ST_STORE  = 2'd3
  } acq_state_e;
endpackage

// File: rtl/acq_track_edge.sv
module acq_track_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic track,
  output logic rise
);
  logic track_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) track_q <= 1'b1;
    else        track_q <= track;
  end

  assign rise = track & ~track_q;
endmodule

// File: rtl/acq_sar_core.sv
module acq_sar_core #(
  parameter int unsigned CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic              cmp_ge,
  output logic [CODE_W-1:0] trial,
  output logic              last_step,
  output logic [CODE_W-1:0] result
);
  localparam int unsigned STEP_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [STEP_W-1:0] TOP_BIT = STEP_W'(CODE_W - 1);

  logic [CODE_W-1:0] acc;
  logic [STEP_W-1:0] bitpos;

  function automatic logic [CODE_W-1:0] trial_of(input logic [CODE_W-1:0] kept,
                                                 input logic [STEP_W-1:0] pos);
    logic [CODE_W-1:0] probe;
    probe = '0;
    probe[pos] = 1'b1;
    return kept | probe;
  endfunction

  function automatic logic [CODE_W-1:0] keep_or_drop(input logic [CODE_W-1:0] kept,
                                                     input logic [CODE_W-1:0] cand,
                                                     input logic ge);
    return ge ? cand : kept;
  endfunction

  assign trial     = trial_of(acc, bitpos);
  assign last_step = run && (bitpos == '0);
  assign result    = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      bitpos <= TOP_BIT;
    end else if (start) begin
      acc    <= '0;
      bitpos <= TOP_BIT;
    end else if (run) begin
      acc    <= keep_or_drop(acc, trial, cmp_ge);
      if (bitpos != '0) bitpos <= bitpos - 1'b1;
    end
  end
endmodule

// File: rtl/acq_sel_decode.sv
module acq_sel_decode #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              tgt_cal,
  input  logic              tgt_ofs,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic [NUM_CH:0]   mask
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign mask[i] = tgt_cal | (~tgt_ofs & (tgt_addr == ADDR_W'(i)));
  end
  assign mask[NUM_CH] = tgt_ofs & ~tgt_cal;
endmodule

// File: rtl/acq_code_bank.sv
module acq_code_bank #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CODE_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [NUM_CH:0]          wr_mask,
  input  logic [CODE_W-1:0]        wr_data,
  output logic [NUM_CH*CODE_W-1:0] ch_code,
  output logic [CODE_W-1:0]        ofs_code
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
    logic [CODE_W-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  val <= '0;
      else if (wr_en && wr_mask[i]) val <= wr_data;
    end
    assign ch_code[i*CODE_W +: CODE_W] = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ofs_code <= '0;
    else if (wr_en && wr_mask[NUM_CH]) ofs_code <= wr_data;
  end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int unsigned NUM_CH = acq_pkg::ACQ_NCH_DEF,
  parameter int unsigned CODE_W = acq_pkg::ACQ_CODE_W_DEF,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     addr_strobe,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     ofs_sel,
  input  logic                     cal,
  input  logic                     track,
  input  logic                     cmp_ge,
  output logic [CODE_W-1:0]        trial_code,
  output logic                     busy_n,
  output logic [NUM_CH*CODE_W-1:0] ch_code,
  output logic [CODE_W-1:0]        ofs_code,
  output logic [NUM_CH-1:0]        buf_src_in,
  output logic                     ofs_src_in
);
  acq_state_e        state, state_nx;
  logic              tgt_cal, tgt_ofs;
  logic [ADDR_W-1:0] tgt_addr;
  logic [NUM_CH:0]   tgt_mask;
  logic [CODE_W-1:0] sar_trial, sar_result;
  logic              sar_last;

  logic idle, strobe_taken, strobe_dropped, trk_rise;
  logic acq_start, acq_store, searching, sel_active;

  assign idle           = (state == ST_IDLE);
  assign searching      = (state == ST_SEARCH);
  assign acq_store      = (state == ST_STORE);
  assign strobe_taken   = addr_strobe & idle;
  assign strobe_dropped = addr_strobe & ~idle;
  assign acq_start      = (strobe_taken & track) | ((state == ST_HOLD) & trk_rise);
  assign sel_active     = ~idle;

  acq_track_edge u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .track (track),
    .rise  (trk_rise)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (strobe_taken) state_nx = track ? ST_SEARCH : ST_HOLD;
      ST_HOLD:   if (trk_rise)     state_nx = ST_SEARCH;
      ST_SEARCH: if (sar_last)     state_nx = ST_STORE;
      ST_STORE:                    state_nx = ST_IDLE;
      default:                     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tgt_cal  <= 1'b0;
      tgt_ofs  <= 1'b0;
      tgt_addr <= '0;
    end else begin
      state <= state_nx;
      if (strobe_taken) begin
        tgt_cal  <= cal;
        tgt_ofs  <= ofs_sel;
        tgt_addr <= addr;
      end
    end
  end

  acq_sar_core #(.CODE_W(CODE_W)) u_sar (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (acq_start),
    .run       (searching),
    .cmp_ge    (cmp_ge),
    .trial     (sar_trial),
    .last_step (sar_last),
    .result    (sar_result)
  );

  acq_sel_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .tgt_cal  (tgt_cal),
    .tgt_ofs  (tgt_ofs),
    .tgt_addr (tgt_addr),
    .mask     (tgt_mask)
  );

  acq_code_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acq_store),
    .wr_mask  (tgt_mask),
    .wr_data  (sar_result),
    .ch_code  (ch_code),
    .ofs_code (ofs_code)
  );

  assign trial_code = searching ? sar_trial : '0;
  assign busy_n     = ~(searching | acq_store);
  assign buf_src_in = sel_active ? tgt_mask[NUM_CH-1:0] : '0;
  assign ofs_src_in = sel_active & tgt_mask[NUM_CH];
endmodule

// File: rtl/acq_sequencer_chk.sv
module acq_sequencer_chk #(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned CODE_W = 14,
  parameter int unsigned ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy_n,
  input logic                     acq_start,
  input logic                     acq_store,
  input logic                     strobe_dropped,
  input logic                     tgt_cal,
  input logic                     tgt_ofs,
  input logic [ADDR_W-1:0]        tgt_addr,
  input logic [CODE_W-1:0]        trial_code,
  input logic [NUM_CH*CODE_W-1:0] ch_code,
  input logic [CODE_W-1:0]        ofs_code,
  input logic [NUM_CH-1:0]        buf_src_in,
  input logic                     ofs_src_in
);
  localparam int unsigned BUDGET = CODE_W + 1;
  localparam int unsigned CNT_W  = $clog2(BUDGET + 2) + 1;

  logic [CNT_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= '0;
    else if (busy_n) low_run <= '0;
    else if (low_run != {CNT_W{1'b1}}) low_run <= low_run + 1'b1;
  end

  assert_store_releases_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acq_store |=> busy_n);

  assert_busy_falls_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> $past(acq_start));

  assert_trial_zero_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> (trial_code == '0));

  assert_regs_change_on_store_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_store |=> ($stable(ch_code) && $stable(ofs_code)));

  assert_single_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_cal |-> $onehot0({ofs_src_in, buf_src_in}));

  assert_buffer_on_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (|{ofs_src_in, buf_src_in}));

  assert_cal_all_buffers_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_cal && !busy_n) |-> ((&buf_src_in) && !ofs_src_in));

  assert_drop_keeps_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_dropped |=> ($stable(tgt_cal) && $stable(tgt_ofs) && $stable(tgt_addr)));

  assert_busy_budget_R10: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= CNT_W'(BUDGET));
endmodule

bind acq_sequencer acq_sequencer_chk #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy_n         (busy_n),
  .acq_start      (acq_start),
  .acq_store      (acq_store),
  .strobe_dropped (strobe_dropped),
  .tgt_cal        (tgt_cal),
  .tgt_ofs        (tgt_ofs),
  .tgt_addr       (tgt_addr),
  .trial_code     (trial_code),
  .ch_code        (ch_code),
  .ofs_code       (ofs_code),
  .buf_src_in     (buf_src_in),
  .ofs_src_in     (ofs_src_in)
);

// File: tb/tb_acq_sequencer.sv
module tb_acq_sequencer;
  localparam int NCH = 32;
  localparam int CW  = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            addr_strobe = 1'b0;
  logic [4:0]      addr = '0;
  logic            ofs_sel = 1'b0;
  logic            cal = 1'b0;
  logic            track = 1'b1;
  logic            cmp_ge;
  logic [CW-1:0]   trial_code;
  logic            busy_n;
  logic [NCH*CW-1:0] ch_code;
  logic [CW-1:0]   ofs_code;
  logic [NCH-1:0]  buf_src_in;
  logic            ofs_src_in;

  logic [CW-1:0]   vin = '0;
  int              exp_reg [NCH+1];
  int              n_chk = 0;
  int              n_bad = 0;

  always #2 clk = ~clk;

  assign cmp_ge = (vin >= trial_code);

  acq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .addr(addr),
    .ofs_sel(ofs_sel), .cal(cal), .track(track), .cmp_ge(cmp_ge),
    .trial_code(trial_code), .busy_n(busy_n), .ch_code(ch_code),
    .ofs_code(ofs_code), .buf_src_in(buf_src_in), .ofs_src_in(ofs_src_in)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int reg_of(input int i);
    if (i == NCH) return int'(ofs_code);
    return int'(ch_code[i*CW +: CW]);
  endfunction

  task automatic check_bank(input string req);
    int mism = 0;
    int first = -1;
    for (int i = 0; i <= NCH; i++) begin
      if (reg_of(i) != exp_reg[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    end
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, reg_of(first), exp_reg[first]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i <= NCH; i++) exp_reg[i] = 0;
  endtask

  task automatic drive_strobe(input int a, input bit o, input bit c, input bit trk);
    @(negedge clk);
    addr = 5'(a); ofs_sel = o; cal = c; track = trk; addr_strobe = 1'b1;
    @(negedge clk);
    addr_strobe = 1'b0;
  endtask

  function automatic longint exp_mask(input int a, input bit o, input bit c);
    if (c) return {1'b0, {NCH{1'b1}}};
    if (o) return longint'(1) << NCH;
    return longint'(1) << a;
  endfunction

  task automatic wait_busy(output int cnt, input longint m, input string req_buf);
    cnt = 0;
    while (!busy_n && cnt < 40) begin
      if (cnt == 0 || cnt == 14)
        chk({ofs_src_in, buf_src_in} == m[NCH:0], req_buf, {ofs_src_in, buf_src_in}, m);
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_acquire(input int a, input bit o, input bit c, input int v, input string req);
    int cnt;
    longint m;
    m = exp_mask(a, o, c);
    vin = CW'(v);
    drive_strobe(a, o, c, 1'b1);
    wait_busy(cnt, m, "R5 buffer select during acquisition");
    chk(cnt == 15, "R2 busy length", cnt, 15);
    if (c) for (int i = 0; i < NCH; i++) exp_reg[i] = v;
    else if (o) exp_reg[NCH] = v;
    else exp_reg[a] = v;
    check_bank(req);
    chk({ofs_src_in, buf_src_in} == '0, "R5 buffers back to DAC", {ofs_src_in, buf_src_in}, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(busy_n == 1'b1, "R1 busy_n after reset", busy_n, 1);
    chk(trial_code == '0, "R1 trial_code after reset", trial_code, 0);
    chk({ofs_src_in, buf_src_in} == '0, "R1 buffer selects after reset", {ofs_src_in, buf_src_in}, 0);
    check_bank("R1 registers zero after reset");
  endtask

  task automatic t_trial_sequence();
    int kept = 0;
    int v = 'h2AAA;
    int t;
    vin = CW'(v);
    drive_strobe(11, 1'b0, 1'b0, 1'b1);
    for (int b = CW - 1; b >= 0; b--) begin
      t = kept | (1 << b);
      chk(int'(trial_code) == t, "R3 trial code per step", trial_code, t);
      if (v >= t) kept = t;
      @(negedge clk);
    end
    chk(trial_code == '0, "R3 trial zero in store cycle", trial_code, 0);
    chk(busy_n == 1'b0, "R2 busy low in store cycle", busy_n, 0);
    @(negedge clk);
    exp_reg[11] = kept;
    chk(busy_n == 1'b1, "R2 busy high after store", busy_n, 1);
    check_bank("R4 stored code equals search result");
  endtask

  task automatic t_track_defer();
    int cnt;
    vin = CW'(1234);
    drive_strobe(5, 1'b0, 1'b0, 1'b0);
    repeat (4) begin
      chk(busy_n == 1'b1, "R6 busy stays high while track low", busy_n, 1);
      chk(buf_src_in == (32'h1 << 5), "R6 buffer follows input while waiting", buf_src_in, 32'h1 << 5);
      @(negedge clk);
    end
    drive_strobe(8, 1'b0, 1'b0, 1'b0);
    check_bank("R9 strobe while waiting leaves registers");
    vin = CW'(4321);
    track = 1'b1;
    @(negedge clk);
    wait_busy(cnt, exp_mask(5, 1'b0, 1'b0), "R9 target kept after dropped strobe");
    chk(cnt == 15, "R6 deferred acquisition busy length", cnt, 15);
    exp_reg[5] = 4321;
    check_bank("R6 deferred acquisition uses input at track rise");
  endtask

  task automatic t_ignore_busy();
    vin = CW'(500);
    drive_strobe(3, 1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    addr = 5'd9; addr_strobe = 1'b1;
    @(negedge clk);
    addr_strobe = 1'b0;
    while (!busy_n) @(negedge clk);
    exp_reg[3] = 500;
    check_bank("R9 strobe during search ignored");
    for (int k = 0; k < 20; k++) begin
      if (!busy_n) begin
        chk(1'b0, "R9 no second acquisition", busy_n, 1);
        break;
      end
      @(negedge clk);
    end
    chk(busy_n == 1'b1, "R9 busy high after dropped strobe", busy_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_acquire(0, 1'b0, 1'b0, 'h1555, "R4 channel 0 pattern 1555");
    t_acquire(31, 1'b0, 1'b0, 'h3FFF, "R4 channel 31 full scale");
    t_acquire(17, 1'b0, 1'b0, 0, "R4 channel 17 zero code");
    t_acquire(17, 1'b0, 1'b0, 'h2001, "R4 channel 17 overwrite");
    t_trial_sequence();
    t_acquire(4, 1'b1, 1'b0, 777, "R7 offset register, address ignored");
    t_acquire(0, 1'b1, 1'b1, 'h0ABC, "R8 calibration writes all channels, cal over ofs_sel");
    t_acquire(2, 1'b0, 1'b0, 99, "R4 single channel after calibration");
    t_track_defer();
    t_ignore_busy();
    t_reset_state();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule